// File: doc/BRIEF.md
# Three-Line Byte Handshake Transfer Engine

This block is the device end of a byte-wide link to a host. Three active-low lines carry the handshake. The host drives "in progress" (`tip_n`) for the length of a packet and toggles "acknowledge" (`ack_n`) to step from one byte to the next. The device drives "request" (`req_n`) back to the host. Each byte passes through an 8-bit shift data register. The bit-serial shifting of that register happens elsewhere, as does decoding what the packets mean.

A direction input selects which way bytes move. In outbound mode (host to device), each handshake step copies the shift register into the next slot of a 16-entry collection buffer. When the host releases in-progress, the engine emits a one-cycle packet-complete pulse that carries the byte count. In inbound mode (device to host), a reply packet of up to 128 bytes is first written and armed. Each handshake step then loads the next reply byte into the shift register. While a reply is waiting and the host is idle, request is pulled low.

Every accepted byte raises the shift-register interrupt flag, and so does the end of each packet. When the host is idle, acknowledge edges drive request to follow the acknowledge level, which lets the host resynchronise.

Top module: `hsx_link_engine`

## Requirements
- R1: After synchronous reset, `req_n` is 1, `sr_flag` is 0, `pkt_done` is 0 and `sr_q` is 0.
- R2: While `tip_n`=0 and `dir_out`=1, a cycle in which `tip_n` or `ack_n` differs from its value on the previous cycle stores `sr_q` into collection slot N, where N is the number of bytes already held. The count then increments and `sr_flag` is set. Slot k can be read on `ob_rdata` by setting `ob_raddr`=k.
- R3: Once 16 bytes are held, further outbound steps are dropped. The stored bytes and the count are unchanged, and `sr_flag` is not set by the dropped step.
- R4: While `tip_n`=0 and `dir_out`=0, a step (as in R2) with reply bytes pending loads the next reply byte into `sr_q` and sets `sr_flag`. A step with nothing pending changes neither.
- R5: The step that delivers the last reply byte drives `req_n` to 1.
- R6: A cycle with `tip_n`=1 now and on the previous cycle, and an `ack_n` change, drives `req_n` to the new `ack_n` level and sets `sr_flag`.
- R7: On the first cycle with `tip_n`=1 after `tip_n`=0, `sr_flag` is set. If the count N is above zero, `pkt_done` is 1 for exactly one cycle with `pkt_len`=N, and N returns to 0. If N is zero, no pulse is produced.
- R8: While `tip_n`=1 and no R6 step occurs, pending reply bytes drive `req_n` to 0.
- R9: `rpl_go` arms a reply whose bytes were written at `rpl_addr` 0 upward. The reply length is min(`rpl_len`, 128), and delivery restarts at byte 0.
- R10: `flag_clr` clears `sr_flag`. A set in the same cycle takes priority over the clear.
- R11: `sr_wr` loads `sr_wdata` into `sr_q` on a cycle with no inbound load.
- R12: While `tip_n` stays 0 and `ack_n` is unchanged, no byte moves and `req_n` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tip_n | input | 1 | Host transfer-in-progress line, active low |
| ack_n | input | 1 | Host acknowledge line, active low |
| req_n | output | 1 | Device request line to host, active low |
| dir_out | input | 1 | 1 = host-to-device collection, 0 = reply delivery |
| sr_wr | input | 1 | Write strobe for the shift data register |
| sr_wdata | input | 8 | Value written into the shift data register |
| sr_q | output | 8 | Shift data register contents |
| sr_flag | output | 1 | Shift-register interrupt flag |
| flag_clr | input | 1 | Clear strobe for the flag |
| rpl_we | input | 1 | Reply buffer write strobe |
| rpl_addr | input | 7 | Reply buffer write address |
| rpl_wdata | input | 8 | Reply buffer write data |
| rpl_go | input | 1 | Arm the reply buffer for delivery |
| rpl_len | input | 8 | Requested reply length (clamped to 128) |
| ob_raddr | input | 4 | Collection buffer read address |
| ob_rdata | output | 8 | Collection buffer read data |
| pkt_done | output | 1 | One-cycle outbound packet-complete pulse |
| pkt_len | output | 5 | Byte count that goes with `pkt_done` |

## Verification
The assertions assume that the host holds `tip_n` and `ack_n` high during reset. Under that assumption, the edge-detection registers, which reset to the idle level, agree with the previous-cycle values the properties read. They also assume the handshake lines change only between clock edges. The bench drives every input two time units after a rising edge, keeps both lines high until after reset, and does not write the shift register in the same cycle as a handshake step. Packet lengths run from 0 to 18 outbound and from 1 to 128 inbound, so both the overflow and the clamp paths are reached.

// File: rtl/hsx_pkg.sv
// Shared types for the byte handshake engine.
// Assumes 8-bit bytes throughout.
package hsx_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // What the handshake logic decided to do on the current cycle
    typedef enum logic [2:0] {
        XFER_NONE = 3'd0,
        XFER_OUT  = 3'd1,   // collect shift register into buffer
        XFER_IN   = 3'd2,   // load shift register from reply
        XFER_SYNC = 3'd3,   // idle: request mirrors acknowledge
        XFER_END  = 3'd4    // in-progress just released
    } xfer_kind_t;

endpackage

// File: rtl/hsx_edge.sv
// Keeps the previous sample of the two host handshake lines and reports
// changes against the current sample. Assumes the lines are already
// synchronous to clk. The registers reset to the idle (high) level.
module hsx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tip_n,
    input  logic ack_n,
    output logic prev_tip_n,
    output logic moved,
    output logic ack_moved
);

    logic prev_ack_n;

    // Register last-cycle line levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_tip_n <= 1'b1;
            prev_ack_n <= 1'b1;
        end else begin
            prev_tip_n <= tip_n;
            prev_ack_n <= ack_n;
        end
    end

    // Any change on either line, and acknowledge change alone
    always_comb begin
        ack_moved = (ack_n != prev_ack_n);
        moved     = ack_moved || (tip_n != prev_tip_n);
    end

endmodule

// File: rtl/hsx_collect.sv
// Outbound collection buffer. Appends one byte per push until DEPTH
// bytes are held; pushes beyond that are dropped. clear empties the
// count (contents are kept). Assumes push and clear are never both high.
module hsx_collect #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  hsx_pkg::byte_t       push_data,
    input  logic                 clear,
    input  logic [AW-1:0]        rd_addr,
    output hsx_pkg::byte_t       rd_data,
    output logic [CW-1:0]        count,
    output logic                 full
);

    hsx_pkg::byte_t mem [DEPTH];

    // Buffer is full when the count reaches the depth
    always_comb full = (count == CW'(DEPTH));

    // Byte storage: write the next free slot
    always_ff @(posedge clk) begin
        if (push && !full)
            mem[count[AW-1:0]] <= push_data;
    end

    // Fill count: advance on push, return to zero on clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (push && !full)
            count <= count + CW'(1);
    end

    // Asynchronous read port for the packet consumer
    always_comb rd_data = mem[rd_addr];

endmodule

// File: rtl/hsx_reply.sv
// Inbound reply buffer. Bytes are written by address. arm records a
// length clamped to DEPTH and rewinds the read index. advance steps the
// index. Assumes advance is only raised while pending is high.
module hsx_reply #(
    parameter int DEPTH  = 128,
    parameter int LEN_W  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int IW    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  hsx_pkg::byte_t       wr_data,
    input  logic                 arm,
    input  logic [LEN_W-1:0]     arm_len,
    input  logic                 advance,
    output hsx_pkg::byte_t       cur_data,
    output logic                 pending,
    output logic                 last
);

    hsx_pkg::byte_t mem [DEPTH];
    logic [IW-1:0]  len_q;
    logic [IW-1:0]  idx_q;
    logic [IW-1:0]  arm_len_clamped;

    // Byte storage written by the reply producer
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    // Clamp the requested length to the buffer depth
    always_comb begin
        if (32'(arm_len) > DEPTH)
            arm_len_clamped = IW'(DEPTH);
        else
            arm_len_clamped = IW'(arm_len);
    end

    // Length and read index: arm rewinds, advance steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            idx_q <= '0;
        end else if (arm) begin
            len_q <= arm_len_clamped;
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= idx_q + IW'(1);
        end
    end

    // Current byte and delivery status
    always_comb begin
        pending  = (idx_q < len_q);
        last     = ((idx_q + IW'(1)) == len_q);
        cur_data = mem[idx_q[AW-1:0]];
    end

endmodule

// File: rtl/hsx_link_engine.sv
// Device side of a three-line active-low byte handshake. Handshake steps
// (any change on in-progress or acknowledge while in-progress is low)
// move one byte between the shift register and the collection or reply
// buffer, selected by dir_out. Assumes the host lines are synchronous
// and idle (high) while reset is applied.
module hsx_link_engine #(
    parameter int OB_DEPTH = 16,
    parameter int RB_DEPTH = 128,
    parameter int LEN_W    = 8,
    localparam int OB_AW   = $clog2(OB_DEPTH),
    localparam int OB_CW   = $clog2(OB_DEPTH + 1),
    localparam int RB_AW   = $clog2(RB_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tip_n,
    input  logic             ack_n,
    output logic             req_n,
    input  logic             dir_out,
    input  logic             sr_wr,
    input  logic [7:0]       sr_wdata,
    output logic [7:0]       sr_q,
    output logic             sr_flag,
    input  logic             flag_clr,
    input  logic             rpl_we,
    input  logic [RB_AW-1:0] rpl_addr,
    input  logic [7:0]       rpl_wdata,
    input  logic             rpl_go,
    input  logic [LEN_W-1:0] rpl_len,
    input  logic [OB_AW-1:0] ob_raddr,
    output logic [7:0]       ob_rdata,
    output logic             pkt_done,
    output logic [OB_CW-1:0] pkt_len
);

    import hsx_pkg::*;

    logic             prev_tip_n;
    logic             moved;
    logic             ack_moved;
    logic [OB_CW-1:0] ob_count;
    logic             ob_full;
    byte_t            rb_data;
    logic             rb_pending;
    logic             rb_last;
    xfer_kind_t       kind;

    hsx_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .tip_n      (tip_n),
        .ack_n      (ack_n),
        .prev_tip_n (prev_tip_n),
        .moved      (moved),
        .ack_moved  (ack_moved)
    );

    hsx_collect #(.DEPTH(OB_DEPTH)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (kind == XFER_OUT),
        .push_data (sr_q),
        .clear     (kind == XFER_END),
        .rd_addr   (ob_raddr),
        .rd_data   (ob_rdata),
        .count     (ob_count),
        .full      (ob_full)
    );

    hsx_reply #(.DEPTH(RB_DEPTH), .LEN_W(LEN_W)) u_reply (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rpl_we),
        .wr_addr  (rpl_addr),
        .wr_data  (rpl_wdata),
        .arm      (rpl_go),
        .arm_len  (rpl_len),
        .advance  (kind == XFER_IN && !rpl_go),
        .cur_data (rb_data),
        .pending  (rb_pending),
        .last     (rb_last)
    );

    // Classify this cycle's handshake activity
    always_comb begin
        kind = XFER_NONE;
        if (!tip_n) begin
            if (moved) begin
                if (dir_out) begin
                    if (!ob_full)
                        kind = XFER_OUT;
                end else if (rb_pending) begin
                    kind = XFER_IN;
                end
            end
        end else if (prev_tip_n && ack_moved) begin
            kind = XFER_SYNC;
        end else if (!prev_tip_n) begin
            kind = XFER_END;
        end
    end

    // Request line: end of reply, sync mirror, or pending-data signal
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_n <= 1'b1;
        else if (kind == XFER_IN && rb_last)
            req_n <= 1'b1;
        else if (kind == XFER_SYNC)
            req_n <= ack_n;
        else if (tip_n && rb_pending)
            req_n <= 1'b0;
    end

    // Shift data register: reply load wins over a host write
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (kind == XFER_IN)
            sr_q <= rb_data;
        else if (sr_wr)
            sr_q <= sr_wdata;
    end

    // Interrupt flag: any accepted activity sets, clear strobe resets
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_flag <= 1'b0;
        else if (kind != XFER_NONE)
            sr_flag <= 1'b1;
        else if (flag_clr)
            sr_flag <= 1'b0;
    end

    // Packet-complete pulse with the collected byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_done <= 1'b0;
            pkt_len  <= '0;
        end else begin
            pkt_done <= (kind == XFER_END) && (ob_count != '0);
            pkt_len  <= ob_count;
        end
    end

endmodule

// File: rtl/hsx_link_checker.sv
// Protocol properties for hsx_link_engine, observed at its ports.
// Assumes tip_n and ack_n are high while reset is applied.
module hsx_link_checker #(
    parameter int OB_DEPTH = 16,
    parameter int OB_CW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tip_n,
    input logic             ack_n,
    input logic             req_n,
    input logic             sr_flag,
    input logic             pkt_done,
    input logic [OB_CW-1:0] pkt_len
);

    logic was_in_reset = 1'b0;

    // Remember whether the previous edge saw reset asserted
    always_ff @(posedge clk) was_in_reset <= !rst_n;

    // R1: outputs show the reset state on the first edge after reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        was_in_reset |-> (req_n && !sr_flag && !pkt_done));

    // R7: packet-complete never lasts two cycles
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    // R7: a completion never reports an empty packet
    a_r7_nonzero_len: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len != '0));

    // R3: reported count never exceeds the collection depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (32'(pkt_len) <= OB_DEPTH));

    // R7: releasing in-progress always raises the flag
    a_r7_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tip_n && !$past(tip_n)) |=> sr_flag);

    // R6: idle acknowledge edge makes request follow acknowledge
    a_r6_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (tip_n && $past(tip_n) && !$stable(ack_n)) |=> (req_n == $past(ack_n)) && sr_flag);

    // R12: no line change during a transfer leaves request alone
    a_r12_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tip_n && $stable(tip_n) && $stable(ack_n)) |=> $stable(req_n));

endmodule

bind hsx_link_engine hsx_link_checker #(
    .OB_DEPTH (OB_DEPTH),
    .OB_CW    (OB_CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tip_n    (tip_n),
    .ack_n    (ack_n),
    .req_n    (req_n),
    .sr_flag  (sr_flag),
    .pkt_done (pkt_done),
    .pkt_len  (pkt_len)
);

// File: tb/hsx_link_engine_test.sv
// Sweeps outbound packets of 1..18 bytes, an empty packet, idle sync
// toggles, inbound replies of several lengths, a re-arm and the length clamp.
module hsx_link_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tip_n = 1'b1, ack_n = 1'b1, dir_out = 1'b0;
    logic       sr_wr = 1'b0, flag_clr = 1'b0, rpl_we = 1'b0, rpl_go = 1'b0;
    logic [7:0] sr_wdata = '0, rpl_wdata = '0, rpl_len = '0;
    logic [6:0] rpl_addr = '0;
    logic [3:0] ob_raddr = '0;
    logic       req_n, sr_flag, pkt_done;
    logic [7:0] sr_q, ob_rdata;
    logic [4:0] pkt_len;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hsx_link_engine uut (
        .clk(clk), .rst_n(rst_n), .tip_n(tip_n), .ack_n(ack_n), .req_n(req_n),
        .dir_out(dir_out), .sr_wr(sr_wr), .sr_wdata(sr_wdata), .sr_q(sr_q),
        .sr_flag(sr_flag), .flag_clr(flag_clr), .rpl_we(rpl_we),
        .rpl_addr(rpl_addr), .rpl_wdata(rpl_wdata), .rpl_go(rpl_go),
        .rpl_len(rpl_len), .ob_raddr(ob_raddr), .ob_rdata(ob_rdata),
        .pkt_done(pkt_done), .pkt_len(pkt_len)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    function automatic logic [7:0] out_byte(input int n, input int k);
        return 8'((n * 16 + k * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] in_byte(input int seed, input int k);
        return 8'((k * 13 + seed * 29 + 5) & 255);
    endfunction

    // Host sends n bytes, then releases in-progress
    task automatic out_packet(input int n);
        int held = (n < 16) ? n : 16;
        dir_out = 1'b1;
        for (int k = 0; k < n; k++) begin
            sr_wr = 1'b1; sr_wdata = out_byte(n, k);
            tick();
            sr_wr = 1'b0;
            check("R11 host write", sr_q, out_byte(n, k));
            if (k == 0) tip_n = 1'b0; else ack_n = ~ack_n;
            tick();
            if (k < 16) check("R2 flag per byte", sr_flag, 1);
            else        check("R3 overflow flag", sr_flag, 0);
            clear_flag();
            check("R10 flag cleared", sr_flag, 0);
        end
        tip_n = 1'b1;
        tick();
        check("R7 done pulse", pkt_done, 1);
        check("R7/R3 length", pkt_len, held);
        check("R7 end flag", sr_flag, 1);
        for (int k = 0; k < held; k++) begin
            ob_raddr = 4'(k);
            #1;
            check("R2/R3 stored byte", ob_rdata, out_byte(n, k));
        end
        tick();
        check("R7 one cycle", pkt_done, 0);
        clear_flag();
    endtask

    // Fill and arm a reply, then read nread bytes
    task automatic in_packet(input int nwr, input int arm, input int nread, input int seed);
        int eff = (arm < 128) ? arm : 128;
        for (int k = 0; k < nwr; k++) begin
            rpl_we = 1'b1; rpl_addr = 7'(k); rpl_wdata = in_byte(seed, k);
            tick();
        end
        rpl_we = 1'b0;
        rpl_go = 1'b1; rpl_len = 8'(arm);
        tick();
        rpl_go = 1'b0;
        tick();
        check("R8 pending request", req_n, 0);
        dir_out = 1'b0;
        for (int k = 0; k < nread; k++) begin
            if (k == 0) tip_n = 1'b0; else ack_n = ~ack_n;
            tick();
            check("R4 reply byte", sr_q, in_byte(seed, k));
            check("R4 flag", sr_flag, 1);
            check("R5 request level", req_n, (k == eff - 1) ? 1 : 0);
            clear_flag();
            check("R12 request held", req_n, (k == eff - 1) ? 1 : 0);
        end
        if (nread == eff) begin
            ack_n = ~ack_n;
            tick();
            check("R4 nothing past end", sr_flag, 0);
            check("R4 value kept", sr_q, in_byte(seed, eff - 1));
        end
        tip_n = 1'b1;
        tick();
        check("R7 end flag inbound", sr_flag, 1);
        check("R7 no pulse inbound", pkt_done, 0);
        check("R8 request after release", req_n, (nread < eff) ? 0 : 1);
        clear_flag();
    endtask

    initial begin
        repeat (3) tick();
        check("R1 req_n", req_n, 1);
        check("R1 flag", sr_flag, 0);
        check("R1 done", pkt_done, 0);
        check("R1 sr", sr_q, 0);
        rst_n = 1'b1;
        tick();

        for (int n = 1; n <= 18; n++) out_packet(n);

        // R7: empty packet gives flag but no completion
        dir_out = 1'b0; tip_n = 1'b0;
        tick();
        check("R4 empty step", sr_flag, 0);
        tip_n = 1'b1;
        tick();
        check("R7 empty flag", sr_flag, 1);
        check("R7 empty no pulse", pkt_done, 0);
        clear_flag();

        // R6: idle acknowledge toggles mirror onto request
        for (int i = 0; i < 4; i++) begin
            ack_n = ~ack_n;
            tick();
            check("R6 mirror", req_n, ack_n);
            check("R6 flag", sr_flag, 1);
            clear_flag();
        end

        for (int len = 1; len <= 5; len++) in_packet(len, len, len, len);
        // R9: partial read, then re-arm restarts at byte 0
        in_packet(3, 3, 1, 7);
        in_packet(2, 2, 2, 9);
        // R9: length clamp to 128
        in_packet(128, 200, 128, 11);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule